// File: doc/BRIEF.md
# Interrupt Mask Interval Monitor

This block measures how long a processor keeps each of its two interrupt mask bits set. The first is the ordinary interrupt mask (I). The second is the mask for the non-maskable request line (X). At every instruction boundary the core supplies both mask bits and the value of its free-running cycle counter. For each bit, the block keeps its own tracker. A tracker finds each unbroken stretch during which the bit stays set, measures the stretch in cycles, and keeps the shortest and the longest stretch seen since reset.

A report request returns all four figures one clock later, with a one-cycle valid pulse. A stretch that is still open at report time extends the longest figure by its elapsed length so far. That extension is kept in the tracker. The open stretch does not change the shortest figure. If no stretch has closed yet, the shortest figure is reported as equal to the longest one.

Top module: `irq_mask_interval_mon`

## Requirements
- R1: While rst_ni is low, all four statistic outputs and rpt_valid_o are 0. Each tracker comes out of reset with no open stretch, a longest value of 0, and a shortest value at the unset marker 2^(CNT_W-2)-1.
- R2: A mask bit is looked at only in a cycle where boundary_i is 1. Changes of a mask bit while boundary_i is 0 neither open nor close a stretch.
- R3: A stretch opens at a boundary where its mask bit is 1 and no stretch is open, and cycle_i at that boundary becomes its start. A boundary with the bit at 1 while a stretch is already open leaves the start unchanged.
- R4: A stretch closes at a boundary where its mask bit is 0 and a stretch is open. Its length is cycle_i minus the start, modulo 2^CNT_W. The length replaces the shortest value when smaller and the longest value when larger.
- R5: When report_i is 1 at a clock edge, rpt_valid_o is 1 for the following cycle, and the four outputs load the reported figures at that edge. At all other times the outputs keep their values.
- R6: On a report, an open stretch's elapsed length (cycle_i minus start) replaces the reported and stored longest value when larger. The shortest value is not affected by an open stretch.
- R7: On a report, a shortest value still at the unset marker is output as the reported longest value.
- R8: The I tracker (i_mask_i, i_min_o, i_max_o) and the X tracker (x_mask_i, x_min_o, x_max_o) are identical and fully independent.
- R9: A report and a boundary in the same cycle report the state from before that boundary. The stored longest value then takes the larger of the folded value and any closing length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe; mask bits are sampled here |
| i_mask_i | input | 1 | Interrupt mask bit I |
| x_mask_i | input | 1 | Non-maskable request mask bit X |
| cycle_i | input | CNT_W | Free-running cycle count |
| report_i | input | 1 | Report request |
| i_min_o | output | CNT_W | Shortest reported I stretch |
| i_max_o | output | CNT_W | Longest reported I stretch |
| x_min_o | output | CNT_W | Shortest reported X stretch |
| x_max_o | output | CNT_W | Longest reported X stretch |
| rpt_valid_o | output | 1 | One-cycle pulse after a report request |

## Verification
The bench builds the block with the default CNT_W of 64. Because the bench drives cycle_i directly, it can jump the count far beyond 32 bits in the middle of a run. This exercises the full-width subtraction and comparison paths without waiting those cycles. The 64-bit width keeps the unset marker far above any length the bench produces. That makes the substitution of the longest value for an untouched shortest value an observable event.

// File: rtl/irq_mon_pkg.sv
package irq_mon_pkg;
  localparam int NUM_MASKS = 2;
  localparam int MASK_I    = 0;
  localparam int MASK_X    = 1;
endpackage

// File: rtl/mask_span_tracker.sv
module mask_span_tracker #(
  parameter int CNT_W = 64,
  parameter logic [CNT_W-1:0] UNSET = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             mask_i,
  input  logic [CNT_W-1:0] cycle_i,
  input  logic             report_i,
  input  logic [CNT_W-1:0] fold_max_i,
  output logic             open_o,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  logic             open_q;
  logic [CNT_W-1:0] start_q, min_q, max_q;
  logic             open_evt, close_evt;
  logic [CNT_W-1:0] span_len, max_cand;

  assign open_evt  = boundary_i & mask_i & ~open_q;
  assign close_evt = boundary_i & ~mask_i & open_q;
  assign span_len  = cycle_i - start_q;

  // report fold first, then any closing length
  always_comb begin
    max_cand = max_q;
    if (report_i && fold_max_i > max_cand) max_cand = fold_max_i;
    if (close_evt && span_len > max_cand)  max_cand = span_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      start_q <= '0;
      min_q   <= UNSET;
      max_q   <= '0;
    end else begin
      max_q <= max_cand;
      if (open_evt) begin
        open_q  <= 1'b1;
        start_q <= cycle_i;
      end else if (close_evt) begin
        open_q <= 1'b0;
        if (span_len < min_q) min_q <= span_len;
      end
    end
  end

  assign open_o  = open_q;
  assign start_o = start_q;
  assign min_o   = min_q;
  assign max_o   = max_q;
endmodule

// File: rtl/span_report_fold.sv
module span_report_fold #(
  parameter int CNT_W = 64,
  parameter logic [CNT_W-1:0] UNSET = '1
) (
  input  logic             open_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic [CNT_W-1:0] cycle_i,
  output logic [CNT_W-1:0] rep_min_o,
  output logic [CNT_W-1:0] rep_max_o
);
  logic [CNT_W-1:0] elapsed;

  assign elapsed   = cycle_i - start_i;
  assign rep_max_o = (open_i && elapsed > max_i) ? elapsed : max_i;
  assign rep_min_o = (min_i == UNSET) ? rep_max_o : min_i;
endmodule

// File: rtl/irq_mask_interval_mon.sv
module irq_mask_interval_mon #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             i_mask_i,
  input  logic             x_mask_i,
  input  logic [CNT_W-1:0] cycle_i,
  input  logic             report_i,
  output logic [CNT_W-1:0] i_min_o,
  output logic [CNT_W-1:0] i_max_o,
  output logic [CNT_W-1:0] x_min_o,
  output logic [CNT_W-1:0] x_max_o,
  output logic             rpt_valid_o
);
  import irq_mon_pkg::*;

  localparam logic [CNT_W-1:0] UNSET = {2'b00, {(CNT_W-2){1'b1}}};

  logic [NUM_MASKS-1:0]  mask_vec;
  logic [CNT_W-1:0]      rep_min [NUM_MASKS];
  logic [CNT_W-1:0]      rep_max [NUM_MASKS];
  logic [CNT_W-1:0]      min_q   [NUM_MASKS];
  logic [CNT_W-1:0]      max_q   [NUM_MASKS];

  assign mask_vec[MASK_I] = i_mask_i;
  assign mask_vec[MASK_X] = x_mask_i;

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_trk
    logic             open_w;
    logic [CNT_W-1:0] start_w, min_w, max_w;

    mask_span_tracker #(.CNT_W(CNT_W), .UNSET(UNSET)) u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .boundary_i (boundary_i),
      .mask_i     (mask_vec[g]),
      .cycle_i    (cycle_i),
      .report_i   (report_i),
      .fold_max_i (rep_max[g]),
      .open_o     (open_w),
      .start_o    (start_w),
      .min_o      (min_w),
      .max_o      (max_w)
    );

    span_report_fold #(.CNT_W(CNT_W), .UNSET(UNSET)) u_fold (
      .open_i    (open_w),
      .start_i   (start_w),
      .min_i     (min_w),
      .max_i     (max_w),
      .cycle_i   (cycle_i),
      .rep_min_o (rep_min[g]),
      .rep_max_o (rep_max[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        min_q[g] <= '0;
        max_q[g] <= '0;
      end else if (report_i) begin
        min_q[g] <= rep_min[g];
        max_q[g] <= rep_max[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rpt_valid_o <= 1'b0;
    else         rpt_valid_o <= report_i;
  end

  assign i_min_o = min_q[MASK_I];
  assign i_max_o = max_q[MASK_I];
  assign x_min_o = min_q[MASK_X];
  assign x_max_o = max_q[MASK_X];
endmodule

// File: rtl/irq_mask_interval_mon_chk.sv
module irq_mask_interval_mon_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             report_i,
  input logic [CNT_W-1:0] i_min_o,
  input logic [CNT_W-1:0] i_max_o,
  input logic [CNT_W-1:0] x_min_o,
  input logic [CNT_W-1:0] x_max_o,
  input logic             rpt_valid_o
);
  assert_valid_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_i |=> rpt_valid_o);

  assert_valid_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> $past(report_i));

  assert_hold_outputs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_valid_o |-> ($stable(i_min_o) && $stable(i_max_o) &&
                      $stable(x_min_o) && $stable(x_max_o)));

  assert_i_min_le_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> i_min_o <= i_max_o);

  assert_x_min_le_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> x_min_o <= x_max_o);
endmodule

bind irq_mask_interval_mon irq_mask_interval_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .report_i    (report_i),
  .i_min_o     (i_min_o),
  .i_max_o     (i_max_o),
  .x_min_o     (x_min_o),
  .x_max_o     (x_max_o),
  .rpt_valid_o (rpt_valid_o)
);

// File: tb/irq_mask_interval_mon_bench.sv
`timescale 1ns/1ps
module irq_mask_interval_mon_bench;
  localparam int CNT_W = 64;
  localparam longint unsigned UNSET = (64'd1 << 62) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, im = 1'b0, xm = 1'b0, rpt = 1'b0;
  logic [CNT_W-1:0] cycle = '0;
  logic [CNT_W-1:0] i_min, i_max, x_min, x_max;
  logic valid;

  int n_tests = 0, n_fail = 0;
  longint unsigned cyc = 64'd0, last_cyc = 64'd0;
  string tag = "R1";

  // reference model state
  bit              m_open [2];
  longint unsigned m_start[2], m_min[2], m_max[2];
  longint unsigned e_min[2], e_max[2];
  bit              e_valid;

  always #2 clk = ~clk;

  irq_mask_interval_mon #(.CNT_W(CNT_W)) u_irq_mask_interval_mon (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .i_mask_i(im),
    .x_mask_i(xm), .cycle_i(cycle), .report_i(rpt),
    .i_min_o(i_min), .i_max_o(i_max), .x_min_o(x_min), .x_max_o(x_max),
    .rpt_valid_o(valid));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_open[k] = 0; m_start[k] = 0; m_min[k] = UNSET; m_max[k] = 0;
        e_min[k] = 0; e_max[k] = 0;
      end
      e_valid = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit b;
        longint unsigned nmax, el, len;
        b = (k == 0) ? im : xm;
        nmax = m_max[k];
        if (rpt) begin
          el = cycle - m_start[k];
          if (m_open[k] && el > nmax) nmax = el;
          e_max[k] = nmax;
          e_min[k] = (m_min[k] == UNSET) ? nmax : m_min[k];
        end
        if (boundary) begin
          if (!m_open[k] && b) begin
            m_open[k] = 1; m_start[k] = cycle;
          end else if (m_open[k] && !b) begin
            len = cycle - m_start[k];
            if (len < m_min[k]) m_min[k] = len;
            if (len > nmax) nmax = len;
            m_open[k] = 0;
          end
        end
        m_max[k] = nmax;
      end
      e_valid = rpt;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    n_tests++;
    if (valid !== e_valid || i_min !== e_min[0] || i_max !== e_max[0] ||
        x_min !== e_min[1] || x_max !== e_max[1]) begin
      n_fail++;
      $display("FAIL %s model actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
               tag, valid, i_min, i_max, x_min, x_max,
               e_valid, e_min[0], e_max[0], e_min[1], e_max[1]);
    end
  endtask

  task automatic tick(input logic b, input logic i, input logic x, input logic r);
    @(negedge clk);
    compare();
    boundary = b; im = i; xm = x; rpt = r;
    cycle = cyc; last_cyc = cyc; cyc = cyc + 1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint unsigned a, b, s, r, cl;
    repeat (3) @(negedge clk);
    chk("R1", "valid", valid, 0);
    chk("R1", "i_max", i_max, 0);
    chk("R1", "x_min", x_min, 0);
    rst_n = 1'b1;

    // report with nothing closed: min substitutes max (0)
    tag = "R7";
    tick(0, 0, 0, 1); tick(0, 0, 0, 0);
    chk("R5", "valid", valid, 1);
    chk("R7", "i_min empty", i_min, 0);
    chk("R7", "x_min empty", x_min, 0);
    tick(0, 0, 0, 0);
    chk("R5", "valid drop", valid, 0);

    // back-to-back I stretches 10, 3, 25; mask toggles off-boundary ignored
    tag = "R4";
    tick(1, 1, 0, 0); a = last_cyc;
    for (int n = 0; n < 9; n++) tick(0, n[0], 0, 0);
    tick(1, 0, 0, 0); b = last_cyc;
    chk("R2", "len10 spacing", b - a, 10);
    tick(1, 1, 0, 0); repeat (2) tick(0, 0, 0, 0); tick(1, 0, 0, 0);
    tick(1, 1, 0, 0);
    for (int n = 0; n < 24; n++) tick(n[0], 1, 0, 0);
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 1); tick(0, 0, 0, 0);
    chk("R4", "i_min", i_min, 3);
    chk("R4", "i_max", i_max, 25);
    chk("R8", "x_max untouched", x_max, 0);

    // X stretch at large counts, report mid-stretch
    tag = "R6";
    cyc = 64'h0000_0003_0000_0000;
    tick(1, 0, 1, 0); s = last_cyc;
    for (int n = 0; n < 40; n++) tick(1, 0, 1, 0);
    tick(0, 0, 1, 1); r = last_cyc;
    tick(0, 0, 1, 0);
    chk("R6", "x_max open", x_max, r - s);
    chk("R7", "x_min subst", x_min, r - s);
    chk("R8", "i_min kept", i_min, 3);
    chk("R3", "no restart", r - s, 41);
    repeat (5) tick(0, 0, 1, 0);
    tick(1, 0, 0, 0); cl = last_cyc;
    tick(0, 0, 0, 1); tick(0, 0, 0, 0);
    chk("R4", "x_min closed", x_min, cl - s);
    chk("R4", "x_max closed", x_max, cl - s);

    // close and report in the same cycle
    tag = "R9";
    tick(1, 1, 0, 0); a = last_cyc;
    repeat (49) tick(0, 1, 0, 0);
    tick(1, 0, 0, 1); b = last_cyc;
    tick(0, 0, 0, 0);
    chk("R9", "i_max same-cycle", i_max, b - a);
    chk("R6", "i_min not from open", i_min, 3);
    tick(0, 0, 0, 1); tick(0, 0, 0, 0);
    chk("R9", "i_max stored", i_max, 50);
    chk("R9", "i_min after close", i_min, 3);

    // report while I open short: fold persists, later close shorter than fold impossible
    tag = "R6";
    tick(1, 1, 1, 0);
    repeat (60) tick(0, 1, 1, 0);
    tick(0, 1, 1, 1); tick(0, 1, 1, 0);
    chk("R6", "i_max fold", i_max, 61);
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 1); tick(0, 0, 0, 0);
    chk("R6", "i_max kept", i_max, 63);

    tag = "R5";
    repeat (5) tick(0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule